// File: doc/BRIEF.md
# Priority Interrupt Resolver with In-Service Tracking

This block is the decision core of an eight-line interrupt controller. Raw request lines are synchronized and captured into a pending register, either on rising edges or by following the input level. Pending requests that are not masked compete on a fixed priority, with line 0 the most urgent. A single `intr` output tells the processor that a request is waiting that outranks everything currently being serviced.

The processor answers with a one-cycle acknowledge pulse. The block then moves the winning request from the pending register to the in-service register and returns the winner's index on `ack_idx`. While an in-service bit is set, only strictly more urgent requests can raise `intr`. A non-specific end-of-service pulse retires the most urgent in-service bit. When automatic retirement is selected, an acknowledge never leaves an in-service bit behind.

Top module: `irqc_core`

## Requirements
- R1: After reset, `irr_q`, `isr_q` and `ack_idx` are all zero and `intr` is low.
- R2: With `level_mode` low, a rising edge on `req_in[i]` sets `irr_q[i]` three clocks after the input changes. The bit stays set until acknowledged. A line held high after its acknowledge does not set the bit again.
- R3: With `level_mode` high, `irr_q[i]` follows the synchronized level of `req_in[i]` with the same three-clock latency, and clears when the input falls.
- R4: `mask_in` is registered once. A masked line keeps its `irr_q` bit but cannot raise `intr`, and unmasking lets it raise `intr` one clock later.
- R5: Line 0 has the highest priority and line 7 the lowest. Among qualifying requests, the acknowledge selects the lowest index.
- R6: An acknowledge while `intr` is high clears the winner's `irr_q` bit and presents its index on `ack_idx` from the next clock. `intr` is low in that clock unless another qualifying request remains.
- R7: While `isr_q` is non-zero, only an unmasked request with an index strictly below the lowest set `isr_q` bit can raise `intr`.
- R8: `eoi_pulse` clears the lowest-index set bit of `isr_q`. With `isr_q` empty it has no effect.
- R9: With `auto_eoi` high, an acknowledge leaves `isr_q` unchanged. With it low, the acknowledge sets the winner's `isr_q` bit.
- R10: An acknowledge while `intr` is low changes none of `irr_q`, `isr_q` or `ack_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Raw interrupt request lines, asynchronous |
| mask_in | input | 8 | Mask, 1 blocks the line |
| level_mode | input | 1 | 1 = level-sensitive capture, 0 = rising-edge capture |
| auto_eoi | input | 1 | 1 = acknowledge does not set an in-service bit |
| eoi_pulse | input | 1 | Non-specific end-of-service, one clock |
| ack_pulse | input | 1 | Acknowledge from the processor, one clock |
| intr | output | 1 | A qualifying request is pending |
| ack_idx | output | 3 | Index of the last acknowledged line |
| irr_q | output | 8 | Pending request register |
| isr_q | output | 8 | In-service register |

## Verification
The bench targets in-service blocking with a nested sequence. Line 3 is serviced, line 5 then waits without raising `intr`, and line 1 then pre-empts. A resolver that compared against the wrong in-service bit, or allowed equal priority, would raise `intr` for line 5 or refuse line 1. End-of-service is driven both on a two-deep in-service register and on an empty one. A design that cleared the wrong bit, or corrupted state on an empty register, shows the wrong `isr_q` or a premature `intr`. Further cases cover a held edge-mode line that must not re-request, a masked pending line, automatic retirement, level tracking and an acknowledge with nothing pending. A design that got any of these wrong would return a stray index or leave a spurious in-service bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;
endpackage

// File: rtl/irqc_sync_edge.sv
module irqc_sync_edge #(
   parameter int unsigned N_IN        = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] raw_in,
   output logic [N_IN-1:0] lvl_out,
   output logic [N_IN-1:0] rise_out
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   initial begin
      if (SYNC_STAGES < 2) $error("irqc_sync_edge: SYNC_STAGES must be at least 2");
   end

   logic [N_IN-1:0] chain [SYNC_STAGES];
   logic [N_IN-1:0] prev_q;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= raw_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain[LAST];
   end

   assign lvl_out  = chain[LAST];
   assign rise_out = chain[LAST] & ~prev_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
   parameter int unsigned N_IN  = 8,
   parameter int unsigned IDX_W = $clog2(N_IN)
) (
   input  logic [N_IN-1:0]  pend,
   input  logic [N_IN-1:0]  blk_mask,
   input  logic [N_IN-1:0]  in_svc,
   output logic [N_IN-1:0]  win_oh,
   output logic [IDX_W-1:0] win_idx,
   output logic             any_win
);
   logic [N_IN-1:0] svc_low;
   logic [N_IN-1:0] allow;
   logic [N_IN-1:0] elig;

   // Most urgent in-service bit; everything below its index may pre-empt.
   assign svc_low = in_svc & (~in_svc + N_IN'(1));
   assign allow   = (in_svc == '0) ? '1 : (svc_low - N_IN'(1));
   assign elig    = pend & ~blk_mask & allow;
   assign win_oh  = elig & (~elig + N_IN'(1));
   assign any_win = |elig;

   always_comb begin
      win_idx = '0;
      for (int i = N_IN - 1; i >= 0; i--) begin
         if (elig[i]) win_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irqc_core.sv
module irqc_core #(
   parameter int unsigned N_IN        = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDX_W      = $clog2(N_IN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IN-1:0]  req_in,
   input  logic [N_IN-1:0]  mask_in,
   input  logic             level_mode,
   input  logic             auto_eoi,
   input  logic             eoi_pulse,
   input  logic             ack_pulse,
   output logic             intr,
   output logic [IDX_W-1:0] ack_idx,
   output logic [N_IN-1:0]  irr_q,
   output logic [N_IN-1:0]  isr_q
);
   import irqc_pkg::*;

   initial begin
      if (N_IN < 2)  $error("irqc_core: N_IN must be at least 2");
      if (N_IN > 64) $error("irqc_core: N_IN must not exceed 64");
   end

   trig_e           trig;
   logic [N_IN-1:0] imr_q;
   logic [N_IN-1:0] lvl, rise;
   logic [N_IN-1:0] win_oh;
   logic [IDX_W-1:0] win_idx;
   logic            any_win;
   logic            take;
   logic [N_IN-1:0] clr_irr, set_isr, clr_isr;
   logic [N_IN-1:0] isr_low;

   assign trig = trig_e'(level_mode);

   irqc_sync_edge #(.N_IN(N_IN), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (req_in),
      .lvl_out  (lvl),
      .rise_out (rise)
   );

   irqc_arbiter #(.N_IN(N_IN), .IDX_W(IDX_W)) u_arb (
      .pend     (irr_q),
      .blk_mask (imr_q),
      .in_svc   (isr_q),
      .win_oh   (win_oh),
      .win_idx  (win_idx),
      .any_win  (any_win)
   );

   assign intr    = any_win;
   assign take    = ack_pulse & any_win;
   assign clr_irr = take ? win_oh : '0;
   assign set_isr = (take && !auto_eoi) ? win_oh : '0;
   assign isr_low = isr_q & (~isr_q + N_IN'(1));
   assign clr_isr = eoi_pulse ? isr_low : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) imr_q <= '0;
      else        imr_q <= mask_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q <= '0;
      end else begin
         case (trig)
            TRIG_LEVEL: irr_q <= lvl & ~clr_irr;
            default:    irr_q <= (irr_q & ~clr_irr) | rise;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr_q <= '0;
      else        isr_q <= (isr_q & ~clr_isr) | set_isr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ack_idx <= '0;
      else if (take) ack_idx <= win_idx;
   end
endmodule

// File: rtl/irqc_core_chk.sv
module irqc_core_chk #(
   parameter int unsigned N_IN  = 8,
   parameter int unsigned IDX_W = $clog2(N_IN)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack_pulse,
   input logic             eoi_pulse,
   input logic             auto_eoi,
   input logic             intr,
   input logic [IDX_W-1:0] ack_idx,
   input logic [N_IN-1:0]  irr_q,
   input logic [N_IN-1:0]  isr_q
);
   // R6: a raised intr always has a pending request behind it
   p_intr_has_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> (irr_q != '0));

   // R7: nothing can pre-empt the most urgent line while it is in service
   p_top_svc_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      isr_q[0] |-> !intr);

   // R9: without auto retirement the winner lands in service
   p_ack_sets_svc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pulse && intr && !auto_eoi && !eoi_pulse) |=> isr_q[ack_idx]);

   // R9: with auto retirement the in-service register is untouched
   p_auto_eoi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pulse && intr && auto_eoi && !eoi_pulse) |=> $stable(isr_q));

   // R8: end of service retires exactly one bit
   p_eoi_one_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_pulse && !ack_pulse && isr_q != '0) |=>
         ($countones(isr_q) + 1 == $countones($past(isr_q))));

   // R8: end of service on an empty register has no effect
   p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_pulse && !ack_pulse && isr_q == '0) |=> (isr_q == '0));

   // R10: the returned index only moves on a granted acknowledge
   p_idx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_pulse && intr) |=> $stable(ack_idx));
endmodule

bind irqc_core irqc_core_chk #(.N_IN(N_IN), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack_pulse (ack_pulse),
   .eoi_pulse (eoi_pulse),
   .auto_eoi  (auto_eoi),
   .intr      (intr),
   .ack_idx   (ack_idx),
   .irr_q     (irr_q),
   .isr_q     (isr_q)
);

// File: tb/irqc_core_tb.sv
module irqc_core_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_in = '0;
   logic [7:0] mask_in = '0;
   logic       level_mode = 1'b0;
   logic       auto_eoi = 1'b0;
   logic       eoi_pulse = 1'b0;
   logic       ack_pulse = 1'b0;
   logic       intr;
   logic [2:0] ack_idx;
   logic [7:0] irr_q, isr_q;

   int n_chk = 0;
   int n_bad = 0;
   logic [2:0] exp_q[$];
   string      tag_q[$];
   logic       ack_fire = 1'b0;
   logic [2:0] last_idx = '0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   irqc_core u_dut (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_in(mask_in),
      .level_mode(level_mode), .auto_eoi(auto_eoi), .eoi_pulse(eoi_pulse),
      .ack_pulse(ack_pulse), .intr(intr), .ack_idx(ack_idx),
      .irr_q(irr_q), .isr_q(isr_q)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Driver: pulse acknowledge and queue the index the requirements predict.
   task automatic do_ack(input logic [2:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      last_idx = exp;
      ack_pulse = 1'b1;
      @(negedge clk);
      ack_pulse = 1'b0;
   endtask

   task automatic do_eoi();
      eoi_pulse = 1'b1;
      @(negedge clk);
      eoi_pulse = 1'b0;
   endtask

   always @(posedge clk) ack_fire <= ack_pulse;

   // Monitor: compare the returned index in the half cycle after each acknowledge.
   always @(negedge clk) begin
      if (ack_fire && exp_q.size() > 0) begin
         chk(tag_q.pop_front(), {5'b0, ack_idx}, {5'b0, exp_q.pop_front()});
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      chk("R1 irr", irr_q, 8'h00);
      chk("R1 isr", isr_q, 8'h00);
      chk("R1 intr", {7'b0, intr}, 8'h00);
      chk("R1 idx", {5'b0, ack_idx}, 8'h00);

      // R2 latency and capture
      req_in[3] = 1'b1;
      wait_n(2);
      chk("R2 not yet", irr_q, 8'h00);
      wait_n(1);
      chk("R2 edge set", irr_q, 8'h08);
      chk("R2 intr", {7'b0, intr}, 8'h01);
      do_ack(3'd3, "R6 idx 3");
      chk("R6 irr clear", irr_q, 8'h00);
      chk("R9 isr set", isr_q, 8'h08);
      chk("R6 intr low", {7'b0, intr}, 8'h00);
      wait_n(4);
      chk("R2 held no rerequest", irr_q, 8'h00);
      req_in[3] = 1'b0;

      // R7 blocking and pre-emption
      req_in[5] = 1'b1;
      wait_n(4);
      chk("R7 lower pending", irr_q, 8'h20);
      chk("R7 lower blocked", {7'b0, intr}, 8'h00);
      req_in[1] = 1'b1;
      wait_n(4);
      chk("R7 higher raises", {7'b0, intr}, 8'h01);
      do_ack(3'd1, "R5 idx 1");
      chk("R9 nested isr", isr_q, 8'h0A);
      chk("R6 intr low nested", {7'b0, intr}, 8'h00);
      do_eoi();
      chk("R8 clear lowest", isr_q, 8'h08);
      chk("R7 still blocked", {7'b0, intr}, 8'h00);
      do_eoi();
      chk("R8 empty", isr_q, 8'h00);
      chk("R7 unblocked", {7'b0, intr}, 8'h01);
      do_ack(3'd5, "R5 idx 5");
      do_eoi();
      do_eoi();
      chk("R8 eoi on empty", isr_q, 8'h00);
      chk("R8 irr untouched", irr_q, 8'h00);
      req_in = '0;
      wait_n(4);

      // R4 mask
      mask_in[2] = 1'b1;
      req_in[2] = 1'b1;
      wait_n(4);
      chk("R4 masked pending", irr_q, 8'h04);
      chk("R4 masked no intr", {7'b0, intr}, 8'h00);
      mask_in[2] = 1'b0;
      wait_n(1);
      chk("R4 unmask intr", {7'b0, intr}, 8'h01);
      do_ack(3'd2, "R4 idx 2");
      do_eoi();
      req_in[2] = 1'b0;

      // R5 simultaneous requests
      req_in[6] = 1'b1;
      req_in[4] = 1'b1;
      wait_n(4);
      chk("R5 both pending", irr_q, 8'h50);
      do_ack(3'd4, "R5 idx 4 first");
      chk("R7 six blocked", {7'b0, intr}, 8'h00);
      do_eoi();
      do_ack(3'd6, "R5 idx 6 next");
      do_eoi();
      req_in = '0;
      wait_n(4);

      // R10 acknowledge with nothing pending
      ack_pulse = 1'b1;
      @(negedge clk);
      ack_pulse = 1'b0;
      chk("R10 idx hold", {5'b0, ack_idx}, {5'b0, last_idx});
      chk("R10 irr hold", irr_q, 8'h00);
      chk("R10 isr hold", isr_q, 8'h00);

      // R9 automatic retirement
      auto_eoi = 1'b1;
      req_in[7] = 1'b1;
      wait_n(4);
      do_ack(3'd7, "R9 idx 7");
      chk("R9 auto isr empty", isr_q, 8'h00);
      chk("R9 auto intr low", {7'b0, intr}, 8'h00);
      req_in = '0;
      auto_eoi = 1'b0;
      wait_n(4);

      // R3 level tracking
      level_mode = 1'b1;
      req_in[0] = 1'b1;
      wait_n(3);
      chk("R3 level set", irr_q, 8'h01);
      req_in[0] = 1'b0;
      wait_n(3);
      chk("R3 level follows", irr_q, 8'h00);
      chk("R3 intr low", {7'b0, intr}, 8'h00);

      wait_n(2);
      if (exp_q.size() != 0) chk("R6 queue drained", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule